// File: doc/BRIEF.md
# Monitor Channel Handshake Controller

This block runs the byte-serial maintenance channel that rides in the control bits of every frame of a time-multiplexed line interface. It has two independent halves. The receive half takes command bytes from the master. It confirms each byte by reading it identically in two frames, acknowledges it, and hands it to a command decoder. It also reports the end of each message. The transmit half returns response bytes from the decoder to the master. It presents one byte at a time and moves on only after the master has acknowledged it.

Both directions use a pair of active-low control lines. The sender drives a transmit flag low to offer a byte. The reader drives an acknowledge flag low to confirm a byte. When both lines sit high for two frames in a row, the message has ended. Every message begins with the device address byte 0x81. The receiver discards any message that starts with a different byte. The transmitter inserts the address byte on its own before the decoder's bytes. All sampling happens on the cycle that carries the frame strobe.

Top module: `mon_hs_ctrl`

## Requirements
- R1: While reset is applied and just after it is released, `du_mx_n` and `du_mr_n` are 1, and `rx_valid`, `rx_eom`, `tx_take`, `tx_abort` and `tx_done` are 0.
- R2: A received byte is accepted only when `dd_mx_n` is 0 in two consecutive frames with the same `dd_mon` value. A frame whose value differs from the one before it restarts the comparison.
- R3: On acceptance, `du_mr_n` goes to 0 for exactly one frame and then returns to 1.
- R4: Every accepted byte after the address byte is delivered once, in order, on `rx_data` with a one-cycle `rx_valid` pulse. The address byte itself is not delivered.
- R5: After at least one acknowledged byte, two consecutive frames with `dd_mx_n` = 1 while `du_mr_n` = 1 end the message, and `rx_eom` pulses for one cycle.
- R6: If the first accepted byte of a message is not 0x81, it is not acknowledged. No byte and no end pulse are delivered for that message. All bytes up to the next two consecutive idle frames are ignored, including later 0x81 bytes.
- R7: When `tx_req` is 1 at a frame while the transmitter is idle and `dd_mr_n` is 1, the transmitter drives `du_mx_n` to 0 with `du_mon` = 0x81.
- R8: The transmitter holds its byte until it sees an acknowledgement. For the first byte, the acknowledgement is `dd_mr_n` = 0. For later bytes, it is one frame with `dd_mr_n` = 1 followed by a frame with `dd_mr_n` = 0. On an acknowledgement with `tx_req` = 1, it presents `tx_data` and pulses `tx_take`.
- R9: During a later byte, two consecutive frames with `dd_mr_n` = 1 abort the transfer. `du_mx_n` returns to 1 and `tx_abort` pulses.
- R10: An acknowledgement that arrives with `tx_req` = 0 ends the message. `du_mx_n` returns to 1 and `tx_done` pulses. The transmitter then stays idle while `tx_req` is 0.
- R11: `du_mx_n`, `du_mr_n` and `du_mon` change only on the clock edge that follows a cycle with `frame_tick` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| frame_tick | input | 1 | One-cycle strobe marking the frame's control-bit sample point |
| dd_mx_n | input | 1 | Master's transmit flag, active low |
| dd_mr_n | input | 1 | Master's acknowledge flag for our responses, active low |
| dd_mon | input | DW | Downstream monitor byte |
| du_mx_n | output | 1 | Our transmit flag, active low |
| du_mr_n | output | 1 | Our acknowledge flag for received bytes, active low |
| du_mon | output | DW | Upstream monitor byte |
| rx_valid | output | 1 | One-cycle pulse: `rx_data` holds a new command byte |
| rx_data | output | DW | Received command byte |
| rx_eom | output | 1 | One-cycle pulse: the current accepted message has ended |
| tx_req | input | 1 | Decoder has a response byte waiting |
| tx_data | input | DW | Response byte offered by the decoder |
| tx_take | output | 1 | One-cycle pulse: `tx_data` has been consumed |
| tx_abort | output | 1 | One-cycle pulse: the master aborted the response |
| tx_done | output | 1 | One-cycle pulse: the response ended normally |

## Verification
The properties assume that `frame_tick` is a clean single-cycle strobe. They also assume that the master keeps `dd_mx_n`, `dd_mr_n` and `dd_mon` meaningful at that strobe and follows the double-read and acknowledge conventions. The stimulus honours this by changing the inputs only inside frame tasks, which raise the strobe for one cycle and then leave two quiet cycles. The two directions are exercised in separate phases, so the idle line of one half never gets in the way of the other. Random payload values, lengths, glitch frames, ack-frame flag levels and abort points are drawn within those rules. Directed sequences target the wrong-address and abort paths.

// File: rtl/mch_pkg.sv
package mch_pkg;

  // line levels of the active-low control flags
  localparam logic FLAG_ON  = 1'b0;
  localparam logic FLAG_OFF = 1'b1;

  // receive half: awaiting message, comparing, acknowledging,
  // waiting for flag release, one idle frame seen, discarding, discard idle
  typedef enum logic [2:0] {
    RX_IDLE,
    RX_FIRST,
    RX_VALID,
    RX_NEW,
    RX_GAP,
    RX_DROP,
    RX_DROPGAP
  } rx_st_e;

  // transmit half: idle, first byte pending, later byte pending,
  // acknowledge check after a released acknowledge flag
  typedef enum logic [1:0] {
    TX_IDLE,
    TX_REQ1,
    TX_REQN,
    TX_ACKCHK
  } tx_st_e;

endpackage

// File: rtl/mch_rst_sync.sv
module mch_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  localparam int LAST = STAGES - 1;

  logic [LAST:0] sh_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) sh_q <= '0;
        else         sh_q <= 1'b1;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) sh_q <= '0;
        else         sh_q <= {sh_q[LAST-1:0], 1'b1};
      end
    end
  endgenerate

  assign srst_n = sh_q[LAST];

endmodule

// File: rtl/mch_rx.sv
module mch_rx
  import mch_pkg::*;
#(
  parameter int            DW       = 8,
  parameter logic [DW-1:0] DEV_ADDR = 8'h81
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          mx_n,
  input  logic [DW-1:0] din,
  output logic          mr_n,
  output logic          byte_vld,
  output logic [DW-1:0] byte_out,
  output logic          msg_end
);

  rx_st_e        st_q, st_d;
  logic [DW-1:0] cap_q, cap_d;
  logic          open_q, open_d;
  logic          vld_q, vld_d;
  logic          eom_q, eom_d;

  logic          offered;
  assign offered = (mx_n == FLAG_ON);

  // next-state
  always_comb begin
    st_d   = st_q;
    cap_d  = cap_q;
    open_d = open_q;
    vld_d  = 1'b0;
    eom_d  = 1'b0;
    if (tick) begin
      unique case (st_q)
        RX_IDLE: begin
          if (offered) begin
            cap_d = din;
            st_d  = RX_FIRST;
          end
        end
        RX_FIRST: begin
          if (!offered) begin
            // byte withdrawn before confirmation: counts as an idle frame
            st_d = open_q ? RX_GAP : RX_IDLE;
          end else if (din != cap_q) begin
            cap_d = din;
          end else if (open_q) begin
            st_d  = RX_VALID;
            vld_d = 1'b1;
          end else if (cap_q == DEV_ADDR) begin
            st_d   = RX_VALID;
            open_d = 1'b1;
          end else begin
            st_d = RX_DROP;
          end
        end
        RX_VALID: st_d = RX_NEW;
        RX_NEW: begin
          if (!offered) st_d = RX_GAP;
        end
        RX_GAP: begin
          if (offered) begin
            cap_d = din;
            st_d  = RX_FIRST;
          end else begin
            st_d   = RX_IDLE;
            open_d = 1'b0;
            eom_d  = 1'b1;
          end
        end
        RX_DROP: begin
          if (!offered) st_d = RX_DROPGAP;
        end
        RX_DROPGAP: st_d = offered ? RX_DROP : RX_IDLE;
        default:    st_d = RX_IDLE;
      endcase
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= RX_IDLE;
      cap_q  <= '0;
      open_q <= 1'b0;
    end else if (tick) begin
      st_q   <= st_d;
      cap_q  <= cap_d;
      open_q <= open_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      eom_q <= 1'b0;
    end else begin
      vld_q <= vld_d;
      eom_q <= eom_d;
    end
  end

  assign mr_n     = (st_q == RX_VALID) ? FLAG_ON : FLAG_OFF;
  assign byte_vld = vld_q;
  assign byte_out = cap_q;
  assign msg_end  = eom_q;

endmodule

// File: rtl/mch_tx.sv
module mch_tx
  import mch_pkg::*;
#(
  parameter int            DW       = 8,
  parameter logic [DW-1:0] DEV_ADDR = 8'h81
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          mr_n,
  input  logic          req,
  input  logic [DW-1:0] byte_in,
  output logic          mx_n,
  output logic [DW-1:0] dout,
  output logic          take,
  output logic          abort,
  output logic          done
);

  tx_st_e        st_q, st_d;
  logic          mx_q, mx_d;
  logic [DW-1:0] dout_q, dout_d;
  logic          take_q, take_d;
  logic          abort_q, abort_d;
  logic          done_q, done_d;

  logic          acked;
  assign acked = (mr_n == FLAG_ON);

  // next-state
  always_comb begin
    st_d    = st_q;
    mx_d    = mx_q;
    dout_d  = dout_q;
    take_d  = 1'b0;
    abort_d = 1'b0;
    done_d  = 1'b0;
    if (tick) begin
      unique case (st_q)
        TX_IDLE: begin
          if (req && !acked) begin
            st_d   = TX_REQ1;
            mx_d   = FLAG_ON;
            dout_d = DEV_ADDR;
          end
        end
        TX_REQ1, TX_ACKCHK: begin
          if (acked) begin
            if (req) begin
              dout_d = byte_in;
              take_d = 1'b1;
              st_d   = TX_REQN;
            end else begin
              mx_d   = FLAG_OFF;
              done_d = 1'b1;
              st_d   = TX_IDLE;
            end
          end else if (st_q == TX_ACKCHK) begin
            mx_d    = FLAG_OFF;
            abort_d = 1'b1;
            st_d    = TX_IDLE;
          end
        end
        TX_REQN: begin
          if (!acked) st_d = TX_ACKCHK;
        end
        default: st_d = TX_IDLE;
      endcase
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= TX_IDLE;
      mx_q   <= FLAG_OFF;
      dout_q <= '0;
    end else if (tick) begin
      st_q   <= st_d;
      mx_q   <= mx_d;
      dout_q <= dout_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      take_q  <= 1'b0;
      abort_q <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      take_q  <= take_d;
      abort_q <= abort_d;
      done_q  <= done_d;
    end
  end

  assign mx_n  = mx_q;
  assign dout  = dout_q;
  assign take  = take_q;
  assign abort = abort_q;
  assign done  = done_q;

endmodule

// File: rtl/mon_hs_ctrl.sv
module mon_hs_ctrl #(
  parameter int            DW          = 8,
  parameter logic [DW-1:0] DEV_ADDR    = 8'h81,
  parameter int            SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          frame_tick,
  input  logic          dd_mx_n,
  input  logic          dd_mr_n,
  input  logic [DW-1:0] dd_mon,
  output logic          du_mx_n,
  output logic          du_mr_n,
  output logic [DW-1:0] du_mon,
  output logic          rx_valid,
  output logic [DW-1:0] rx_data,
  output logic          rx_eom,
  input  logic          tx_req,
  input  logic [DW-1:0] tx_data,
  output logic          tx_take,
  output logic          tx_abort,
  output logic          tx_done
);

  logic srst_n;

  mch_rst_sync #(.STAGES(SYNC_STAGES)) rst_i (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  mch_rx #(.DW(DW), .DEV_ADDR(DEV_ADDR)) rx_i (
    .clk      (clk),
    .rst_n    (srst_n),
    .tick     (frame_tick),
    .mx_n     (dd_mx_n),
    .din      (dd_mon),
    .mr_n     (du_mr_n),
    .byte_vld (rx_valid),
    .byte_out (rx_data),
    .msg_end  (rx_eom)
  );

  mch_tx #(.DW(DW), .DEV_ADDR(DEV_ADDR)) tx_i (
    .clk     (clk),
    .rst_n   (srst_n),
    .tick    (frame_tick),
    .mr_n    (dd_mr_n),
    .req     (tx_req),
    .byte_in (tx_data),
    .mx_n    (du_mx_n),
    .dout    (du_mon),
    .take    (tx_take),
    .abort   (tx_abort),
    .done    (tx_done)
  );

endmodule

// File: rtl/mon_hs_chk.sv
module mon_hs_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          frame_tick,
  input logic          du_mx_n,
  input logic          du_mr_n,
  input logic [DW-1:0] du_mon,
  input logic          rx_valid,
  input logic          rx_eom,
  input logic          tx_take,
  input logic          tx_abort,
  input logic          tx_done
);

  // R3: acknowledge is released at the next frame
  assert_ack_one_frame_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_tick && !du_mr_n) |=> du_mr_n);

  // R4: a delivered byte coincides with its acknowledge frame
  assert_byte_acked_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> !du_mr_n);

  // R5: end of message never coincides with a byte delivery
  assert_eom_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(rx_valid && rx_eom));

  // R8: a consumed byte is offered with the flag active
  assert_take_active_R8: assert property (@(posedge clk) disable iff (!rst_n)
    tx_take |-> !du_mx_n);

  // R9: abort leaves the transmit flag released
  assert_abort_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    tx_abort |-> du_mx_n);

  // R10: normal end leaves the flag released, and transmit events are exclusive
  assert_done_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    tx_done |-> du_mx_n);
  assert_tx_events_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({tx_take, tx_abort, tx_done}));

  // R11: line outputs move only after a frame strobe
  assert_frame_paced_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(frame_tick) |-> ($stable(du_mx_n) && $stable(du_mr_n) && $stable(du_mon)));

endmodule

bind mon_hs_ctrl mon_hs_chk #(.DW(DW)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .frame_tick (frame_tick),
  .du_mx_n    (du_mx_n),
  .du_mr_n    (du_mr_n),
  .du_mon     (du_mon),
  .rx_valid   (rx_valid),
  .rx_eom     (rx_eom),
  .tx_take    (tx_take),
  .tx_abort   (tx_abort),
  .tx_done    (tx_done)
);

// File: tb/mon_hs_ctrl_tb_top.sv
module mon_hs_ctrl_tb_top;

  localparam logic [7:0] ADDR = 8'h81;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       frame_tick;
  logic       dd_mx_n, dd_mr_n;
  logic [7:0] dd_mon;
  logic       du_mx_n, du_mr_n;
  logic [7:0] du_mon;
  logic       rx_valid, rx_eom;
  logic [7:0] rx_data;
  logic       tx_req;
  logic [7:0] tx_data;
  logic       tx_take, tx_abort, tx_done;

  always #2 clk = ~clk;

  mon_hs_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .frame_tick(frame_tick),
    .dd_mx_n(dd_mx_n), .dd_mr_n(dd_mr_n), .dd_mon(dd_mon),
    .du_mx_n(du_mx_n), .du_mr_n(du_mr_n), .du_mon(du_mon),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_eom(rx_eom),
    .tx_req(tx_req), .tx_data(tx_data),
    .tx_take(tx_take), .tx_abort(tx_abort), .tx_done(tx_done)
  );

  // decoder model: a queue of response bytes
  logic [7:0] tq [0:15];
  int tidx = 0;
  int tlen = 0;
  assign tx_req  = (tidx < tlen);
  assign tx_data = tq[tidx % 16];

  // event monitors
  logic [7:0] got [0:255];
  int ngot = 0, neom = 0, nabort = 0, ndone = 0;
  always @(posedge clk) begin
    if (tx_take)  tidx   <= tidx + 1;
    if (rx_valid) begin got[ngot % 256] <= rx_data; ngot <= ngot + 1; end
    if (rx_eom)   neom   <= neom + 1;
    if (tx_abort) nabort <= nabort + 1;
    if (tx_done)  ndone  <= ndone + 1;
  end

  int checks = 0, failures = 0;
  bit finished = 0;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic frame(input logic mx, input logic mr, input logic [7:0] d);
    @(negedge clk);
    dd_mx_n = mx; dd_mr_n = mr; dd_mon = d; frame_tick = 1'b1;
    @(negedge clk);
    frame_tick = 1'b0;
    @(negedge clk);
    @(negedge clk);
  endtask

  // one well-formed command message: address then n payload bytes
  task automatic rx_msg(input int n);
    logic [7:0] p [0:7];
    int base, eom0;
    base = ngot; eom0 = neom;
    for (int i = 0; i < n; i++) p[i] = 8'($urandom);
    for (int i = 0; i <= n; i++) begin
      logic [7:0] b;
      b = (i == 0) ? ADDR : p[i-1];
      if ($urandom % 3 == 0) begin
        frame(1'b0, 1'b1, b ^ 8'h5A);
        chk("R2 glitch frame not acked", du_mr_n, 1);
      end
      frame(1'b0, 1'b1, b);
      chk("R2 single read not acked", du_mr_n, 1);
      frame(1'b0, 1'b1, b);
      chk("R3 ack after double read", du_mr_n, 0);
      frame(1'($urandom), 1'b1, b);
      chk("R3 ack lasts one frame", du_mr_n, 1);
      frame(1'b1, 1'b1, 8'($urandom));
    end
    frame(1'b1, 1'b1, 8'h00);
    chk("R4 payload count", ngot - base, n);
    for (int i = 0; i < n; i++) chk("R4 payload byte", got[(base + i) % 256], p[i]);
    chk("R5 end of message", neom - eom0, 1);
  endtask

  // one response message of n bytes, optional abort before byte index ab
  task automatic tx_msg(input int n, input int ab);
    logic [7:0] e [0:7];
    for (int i = 0; i < n; i++) begin
      e[i] = 8'($urandom);
      tq[(tidx + i) % 16] = e[i];
    end
    tlen = tidx + n;
    frame(1'b1, 1'b1, 8'h00);
    chk("R7 flag active", du_mx_n, 0);
    chk("R7 address first", du_mon, ADDR);
    frame(1'b1, 1'b1, 8'h00);
    chk("R8 held without ack", du_mon, ADDR);
    frame(1'b1, 1'b0, 8'h00);
    chk("R8 first payload after ack", du_mon, e[0]);
    for (int i = 1; i <= n; i++) begin
      frame(1'b1, 1'b0, 8'h00);
      chk("R8 held while ack flag stays", du_mon, e[i-1]);
      frame(1'b1, 1'b1, 8'h00);
      chk("R8 held during ack release", du_mx_n, 0);
      if (i == ab) begin
        int a0;
        a0 = nabort;
        frame(1'b1, 1'b1, 8'h00);
        chk("R9 abort releases flag", du_mx_n, 1);
        chk("R9 abort pulse", nabort - a0, 1);
        tlen = tidx;
        return;
      end
      frame(1'b1, 1'b0, 8'h00);
      if (i < n) chk("R8 next byte after ack", du_mon, e[i]);
      else       chk("R10 flag released at end", du_mx_n, 1);
    end
    frame(1'b1, 1'b1, 8'h00);
    chk("R10 stays idle", du_mx_n, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int d0, e0, dn0;
    void'($urandom(32'd2024));
    rst_n = 1'b0; frame_tick = 1'b0;
    dd_mx_n = 1'b1; dd_mr_n = 1'b1; dd_mon = 8'h00;
    repeat (5) @(negedge clk);
    chk("R1 mx idle in reset", du_mx_n, 1);
    chk("R1 mr idle in reset", du_mr_n, 1);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 mx idle after reset", du_mx_n, 1);
    chk("R1 mr idle after reset", du_mr_n, 1);
    chk("R1 pulses low", {rx_valid, rx_eom, tx_take, tx_abort, tx_done}, 0);

    // R11: a pending request without a frame strobe changes nothing
    tq[tidx % 16] = 8'h3C; tlen = tidx + 1;
    repeat (8) @(negedge clk);
    chk("R11 no change without strobe", du_mx_n, 1);
    tlen = tidx;

    // receive: address only, then random messages
    rx_msg(0);
    for (int k = 0; k < 6; k++) rx_msg(1 + ($urandom % 4));

    // R6: wrong address, later address bytes ignored until two idle frames
    d0 = ngot; e0 = neom;
    frame(1'b0, 1'b1, 8'h42);
    frame(1'b0, 1'b1, 8'h42);
    chk("R6 wrong address not acked", du_mr_n, 1);
    for (int i = 0; i < 3; i++) begin
      frame(1'b0, 1'b1, ADDR);
      chk("R6 address ignored while discarding", du_mr_n, 1);
    end
    frame(1'b1, 1'b1, 8'h00);
    frame(1'b0, 1'b1, ADDR);
    frame(1'b0, 1'b1, ADDR);
    chk("R6 single idle frame is no end", du_mr_n, 1);
    frame(1'b1, 1'b1, 8'h00);
    frame(1'b1, 1'b1, 8'h00);
    chk("R6 nothing delivered", ngot - d0, 0);
    chk("R6 no end pulse", neom - e0, 0);
    rx_msg(3);

    // transmit
    dn0 = ndone;
    tx_msg(1, 0);
    chk("R10 done pulse", ndone - dn0, 1);
    tx_msg(3, 2);
    for (int k = 0; k < 5; k++) begin
      int n;
      n = 1 + ($urandom % 4);
      tx_msg(n, ($urandom % 2 == 0) ? 0 : 1 + ($urandom % n));
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule